// File: doc/BRIEF.md
# One-Hot Tap Walker for a Register-Controlled Delay Loop

This block is the control unit of a digital delay-locked loop built around an equal-step delay line. A single active bit in an N-bit register picks one tap of that line. Every clock cycle the block takes one decision from the phase detector and moves the active bit by at most one position. A "longer" request moves it toward a longer delay and a "shorter" request moves it toward a shorter one. A hold input freezes the register once the phase error is inside one unit delay.

Bit index grows with delay: bit 0 is the shortest tap and bit N-1 is the longest. The walk is linear, so lock time grows with the number of stages. The register starts in the middle of the line, which caps the worst-case search at about N/2 decisions.

Two outputs report the block's state. The first tells whether the loop is currently held as locked. The second tells whether a request has just been refused because the active bit was already at one end of the line.

Top module: `tap_walker_ctrl`

## Requirements
- R1: After reset, tap_sel has only bit NUM_TAPS/2 set (bit 8 for the default 16 taps), and both locked and at_limit are 0.
- R2: tap_sel has exactly one bit set in every cycle.
- R3: With hold_en low, req_longer high and req_shorter low, an active bit at position i < NUM_TAPS-1 moves to position i+1 at the next rising edge.
- R4: With hold_en low, req_shorter high and req_longer low, an active bit at position i > 0 moves to position i-1 at the next rising edge.
- R5: While hold_en is high, tap_sel does not change whatever the request inputs are, and locked reads 1 after that edge.
- R6: Once set, locked stays 1 until the first edge at which hold_en is low and exactly one request is high. It reads 0 after that edge, even if the step is refused.
- R7: With hold_en low and both requests high, tap_sel, locked and at_limit all keep their values.
- R8: A longer request at bit NUM_TAPS-1, or a shorter request at bit 0, leaves tap_sel unchanged and sets at_limit. The active bit never wraps around. at_limit clears at the next edge where a step is applied.
- R9: With hold_en low and no request, tap_sel, locked and at_limit keep their values.
- R10: From reset, bit 0 is reached after exactly NUM_TAPS/2 shorter steps and bit NUM_TAPS-1 after NUM_TAPS/2-1 longer steps. A closed loop driven toward any target tap holds at that tap within NUM_TAPS/2+1 decisions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decision clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_longer | input | 1 | Phase detector asks for one more unit of delay |
| req_shorter | input | 1 | Phase detector asks for one less unit of delay |
| hold_en | input | 1 | Phase error within one unit; freeze the tap |
| tap_sel | output | NUM_TAPS | One-hot tap select, bit 0 = shortest delay |
| locked | output | 1 | Loop held as locked |
| at_limit | output | 1 | Last request was refused at an end of the line |

## Verification
The checker examines every cycle. It confirms that tap_sel stays one-hot, that each accepted request shifts the active bit by exactly one position in the requested direction, and that hold and conflicting requests leave the register untouched. It also confirms that a refused request raises at_limit without moving the bit, and that locked follows hold_en and the first single request after it. Some behaviours span many cycles and only the bench's scenarios can show them: the worst-case step counts from the centre to each end, the exact persistence of at_limit across idle and conflicting cycles, and closed-loop convergence against a behavioural delay line to several target taps.

// File: rtl/tap_ctrl_pkg.sv
package tap_ctrl_pkg;

  // One decision per cycle, after the hold input has been taken into account
  typedef enum logic [1:0] {
    STEP_NONE     = 2'd0,
    STEP_LONGER   = 2'd1,
    STEP_SHORTER  = 2'd2,
    STEP_CONFLICT = 2'd3
  } step_req_e;

  // Hold wins over any request; opposing requests cancel
  function automatic step_req_e classify_step(input logic hold,
                                              input logic lng,
                                              input logic shr);
    if (hold)            return STEP_NONE;
    else if (lng && shr) return STEP_CONFLICT;
    else if (lng)        return STEP_LONGER;
    else if (shr)        return STEP_SHORTER;
    else                 return STEP_NONE;
  endfunction

  function automatic logic is_single_step(input step_req_e r);
    return (r == STEP_LONGER) || (r == STEP_SHORTER);
  endfunction

endpackage

// File: rtl/tap_step_decode.sv
module tap_step_decode
  import tap_ctrl_pkg::*;
(
  input  logic      hold_en,
  input  logic      req_longer,
  input  logic      req_shorter,
  output step_req_e step_req,
  output logic      freeze,
  output logic      single_req
);

  always_comb begin
    step_req   = classify_step(hold_en, req_longer, req_shorter);
    freeze     = hold_en;
    single_req = is_single_step(step_req);
  end

endmodule

// File: rtl/tap_onehot_shifter.sv
module tap_onehot_shifter
  import tap_ctrl_pkg::*;
#(
  parameter int NUM_TAPS  = 16,
  parameter int RESET_TAP = NUM_TAPS / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  step_req_e           step_req,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic                step_done,
  output logic                step_refused
);

  localparam int TOP = NUM_TAPS - 1;
  localparam logic [NUM_TAPS-1:0] RESET_VEC = NUM_TAPS'(1) << RESET_TAP;

  logic [NUM_TAPS-1:0] tap_q, tap_up, tap_dn, tap_d;
  logic want_up, want_dn;

  assign want_up      = (step_req == STEP_LONGER);
  assign want_dn      = (step_req == STEP_SHORTER);
  assign step_refused = (want_up && tap_q[TOP]) || (want_dn && tap_q[0]);
  assign step_done    = (want_up || want_dn) && !step_refused;

  // Per-bit neighbour taps; ends take zero, refusal keeps them from being used
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_bit
    if (i == 0) begin : g_low
      assign tap_up[i] = 1'b0;
    end else begin : g_low_n
      assign tap_up[i] = tap_q[i-1];
    end
    if (i == TOP) begin : g_high
      assign tap_dn[i] = 1'b0;
    end else begin : g_high_n
      assign tap_dn[i] = tap_q[i+1];
    end
  end

  always_comb begin
    if (step_done) tap_d = want_up ? tap_up : tap_dn;
    else           tap_d = tap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= RESET_VEC;
    else        tap_q <= tap_d;
  end

  assign tap_sel = tap_q;

endmodule

// File: rtl/tap_lock_status.sv
module tap_lock_status (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic single_req,
  input  logic step_done,
  input  logic step_refused,
  output logic locked,
  output logic at_limit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      at_limit <= 1'b0;
    end else begin
      if (freeze)          locked <= 1'b1;
      else if (single_req) locked <= 1'b0;

      if (step_refused)    at_limit <= 1'b1;
      else if (step_done)  at_limit <= 1'b0;
    end
  end

endmodule

// File: rtl/tap_walker_ctrl.sv
module tap_walker_ctrl
  import tap_ctrl_pkg::*;
#(
  parameter int NUM_TAPS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_longer,
  input  logic                req_shorter,
  input  logic                hold_en,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic                locked,
  output logic                at_limit
);

  localparam int CENTRE_TAP = NUM_TAPS / 2;

  // Named internal events, visible to the bound checker
  step_req_e step_req;
  logic      freeze;
  logic      single_req;
  logic      step_done;
  logic      step_refused;

  tap_step_decode u_decode (
    .hold_en     (hold_en),
    .req_longer  (req_longer),
    .req_shorter (req_shorter),
    .step_req    (step_req),
    .freeze      (freeze),
    .single_req  (single_req)
  );

  tap_onehot_shifter #(
    .NUM_TAPS  (NUM_TAPS),
    .RESET_TAP (CENTRE_TAP)
  ) u_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_req     (step_req),
    .tap_sel      (tap_sel),
    .step_done    (step_done),
    .step_refused (step_refused)
  );

  tap_lock_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .freeze       (freeze),
    .single_req   (single_req),
    .step_done    (step_done),
    .step_refused (step_refused),
    .locked       (locked),
    .at_limit     (at_limit)
  );

endmodule

// File: rtl/tap_walker_ctrl_chk.sv
module tap_walker_ctrl_chk #(
  parameter int NUM_TAPS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_longer,
  input logic                req_shorter,
  input logic                hold_en,
  input logic [NUM_TAPS-1:0] tap_sel,
  input logic                locked,
  input logic                at_limit,
  input logic                step_done,
  input logic                step_refused
);

  // R2
  onehot_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R3
  longer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && req_longer && !req_shorter && !tap_sel[NUM_TAPS-1])
      |=> (tap_sel == ($past(tap_sel) << 1)));

  // R4
  shorter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && req_shorter && !req_longer && !tap_sel[0])
      |=> (tap_sel == ($past(tap_sel) >> 1)));

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> ($stable(tap_sel) && locked));

  // R6
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && (req_longer ^ req_shorter)) |=> !locked);

  // R7
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && req_longer && req_shorter)
      |=> ($stable(tap_sel) && $stable(locked) && $stable(at_limit)));

  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_refused |=> ($stable(tap_sel) && at_limit));

  // R8
  limit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !at_limit);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && !req_longer && !req_shorter) |=> $stable(tap_sel));

endmodule

bind tap_walker_ctrl tap_walker_ctrl_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_longer   (req_longer),
  .req_shorter  (req_shorter),
  .hold_en      (hold_en),
  .tap_sel      (tap_sel),
  .locked       (locked),
  .at_limit     (at_limit),
  .step_done    (step_done),
  .step_refused (step_refused)
);

// File: tb/tap_walker_ctrl_bench.sv
`timescale 1ns/1ps
module tap_walker_ctrl_bench;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_longer = 1'b0;
  logic         req_shorter = 1'b0;
  logic         hold_en = 1'b0;
  logic [N-1:0] tap_sel;
  logic         locked;
  logic         at_limit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int pos;
  bit m_locked;
  bit m_limit;

  always #10 clk = ~clk;  // 50 MHz

  tap_walker_ctrl #(.NUM_TAPS(N)) u_tap_walker_ctrl (
    .clk(clk), .rst_n(rst_n), .req_longer(req_longer), .req_shorter(req_shorter),
    .hold_en(hold_en), .tap_sel(tap_sel), .locked(locked), .at_limit(at_limit)
  );

  function automatic logic [N-1:0] vec_of(input int p);
    logic [N-1:0] v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic int pos_of(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare every output against the model; tap positions are reported as indices
  task automatic check_all(input string tag);
    check($countones(tap_sel) == 1, "R2", "one-hot count", $countones(tap_sel), 1);
    check(tap_sel == vec_of(pos), tag, "tap position", pos_of(tap_sel), pos);
    check(locked == m_locked, tag, "locked", locked, m_locked);
    check(at_limit == m_limit, tag, "at_limit", at_limit, m_limit);
  endtask

  // One decision: drive at falling edge, the edge in between updates, sample at next falling edge
  task automatic step(input bit lng, input bit shr, input bit hold);
    @(negedge clk);
    req_longer = lng; req_shorter = shr; hold_en = hold;
    @(negedge clk);
    req_longer = 0; req_shorter = 0; hold_en = 0;
    if (hold) m_locked = 1;
    else if (lng ^ shr) begin
      m_locked = 0;
      if (lng) begin
        if (pos == N-1) m_limit = 1; else begin pos++; m_limit = 0; end
      end else begin
        if (pos == 0) m_limit = 1; else begin pos--; m_limit = 0; end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_longer = 0; req_shorter = 0; hold_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    pos = N/2; m_locked = 0; m_limit = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1");
  endtask

  task automatic t_walk();
    do_reset();
    repeat (3) begin step(1, 0, 0); check_all("R3"); end
    repeat (2) begin step(0, 1, 0); check_all("R4"); end
    step(0, 0, 0); check_all("R9");
    check(pos_of(tap_sel) == N/2 + 1, "R3", "net position", pos_of(tap_sel), N/2 + 1);
  endtask

  task automatic t_hold_lock();
    do_reset();
    step(0, 1, 0);
    step(1, 0, 1); check_all("R5");
    step(0, 1, 1); check_all("R5");
    step(1, 1, 0); check_all("R7");
    step(0, 0, 0); check_all("R9");
    check(locked == 1'b1, "R6", "locked kept over idle", locked, 1);
    step(1, 0, 0); check_all("R6");
    check(locked == 1'b0, "R6", "locked released", locked, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    repeat (N/2 - 1) step(1, 0, 0);
    check_all("R8");
    step(1, 0, 0); check_all("R8");
    check(at_limit == 1'b1, "R8", "top refusal flag", at_limit, 1);
    step(1, 1, 0); check_all("R7");
    step(0, 0, 0); check_all("R9");
    step(0, 1, 0); check_all("R8");
    check(at_limit == 1'b0, "R8", "flag cleared by step", at_limit, 0);
    step(0, 0, 1);
    step(0, 1, 0); check_all("R6");
    repeat (N) step(0, 1, 0);
    check_all("R8");
    check(tap_sel == vec_of(0), "R8", "no wrap at bottom", pos_of(tap_sel), 0);
  endtask

  task automatic t_worst_case();
    int n;
    do_reset();
    n = 0;
    while (!tap_sel[0] && n < 2*N) begin step(0, 1, 0); n++; end
    check(n == N/2, "R10", "steps centre to bottom", n, N/2);
    do_reset();
    n = 0;
    while (!tap_sel[N-1] && n < 2*N) begin step(1, 0, 0); n++; end
    check(n == N/2 - 1, "R10", "steps centre to top", n, N/2 - 1);
  endtask

  // Behavioural delay line and detector: integer tap count against a target
  task automatic t_closed_loop(input int target);
    int n;
    int p;
    do_reset();
    n = 0;
    while (!locked && n < 4*N) begin
      p = pos_of(tap_sel);
      step(p < target, p > target, p == target);
      n++;
    end
    check_all("R10");
    check(pos_of(tap_sel) == target, "R10", "lock tap", pos_of(tap_sel), target);
    check(n <= N/2 + 1, "R10", "decisions to lock", n, N/2 + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_walk();
    t_hold_lock();
    t_saturate();
    t_worst_case();
    t_closed_loop(0);
    t_closed_loop(3);
    t_closed_loop(12);
    t_closed_loop(N-1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule